// File: doc/BRIEF.md
# Serial-Audio FIFO and Interrupt Register Unit

This block is the bus-facing register front end of a stereo serial-audio port. A host reads and writes a small set of word registers: a main control word, a framing options word, a read-only status word, an interrupt enable word, a write-one-to-clear acknowledge word, a bit-clock divider and one data window. A write to the data window queues a 32-bit word for playback; a read of the data window takes the oldest captured word. The serializer that shifts bits on the wire sits outside and talks to this unit through single-cycle pop (playback side) and push (capture side) strobes.

Each queue raises its own service request against a 4-bit level threshold held in the main control word, so a DMA engine or the host knows when to refill or drain. Playback starvation and capture overflow are latched as sticky error flags that stay set until acknowledged. The four conditions, each gated by its own enable bit, are ORed onto one interrupt line. A soft-reset bit in the main control word returns both queues and every other register to their reset state for as long as it is held.

Top module: `aud_fifo_regs`

## Requirements
- R1: After reset every writable register reads 0 and the status word at 0x0C reads 0x99 (off, capture request, playback request, playback not full).
- R2: Byte offsets: 0x00 main control (bits 15:8 and 5:0 kept), 0x04 framing options (bits 5:0 kept), 0x14 interrupt enable (bits 6:3 kept), 0x60 divider (DIV_W bits kept); a write is readable at the same offset from the next cycle, unused bits read 0.
- R3: Words written to offset 0x80 leave on tx_word in write order, one per tx_pop; the playback queue holds 16 words, a write to a full queue is dropped, and status bit 0 is 1 while the playback queue is not full.
- R4: Words pushed with rx_push are returned in push order by reads of offset 0x80; sixteen reads drain a full capture queue, and a read of an empty capture queue returns 0 and changes nothing.
- R5: An rx_push while the capture queue holds 16 words drops the word and sets sticky status bit 6.
- R6: A tx_pop while the playback queue is empty drives tx_word to 0 and sets sticky status bit 5.
- R7: Writing 1 to bit 6 or bit 5 of offset 0x18 clears the matching sticky flag from the next cycle; a 0 in that bit leaves the flag unchanged.
- R8: The playback request (tx_dreq and status bit 3) is 1 while the playback level is at or below main control bits 11:8.
- R9: The capture request (rx_dreq and status bit 4) is 1 while the capture level is at or above main control bits 15:12.
- R10: irq is 1 exactly when some condition is enabled: interrupt enable bit 6 for overrun, bit 5 for underrun, bit 4 for capture request, bit 3 for playback request.
- R11: While main control bit 3 is 1, both queues are empty, sticky flags are clear, all other writable registers read 0 and writes to them are ignored; main control itself keeps its value.
- R12: link_en follows main control bit 0 and bclk_dir bit 2; status bit 7 is 1 while the link is off, bit 2 (busy) is 1 while the link is on and the playback queue is not empty, bit 1 is 1 while the capture queue is not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops capture queue at 0x80) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| tx_pop | input | 1 | Serializer takes the playback head word |
| tx_word | output | 32 | Playback head word, 0 when empty |
| rx_push | input | 1 | Serializer delivers a captured word |
| rx_word | input | 32 | Captured word |
| tx_dreq | output | 1 | Playback service request |
| rx_dreq | output | 1 | Capture service request |
| irq | output | 1 | Combined interrupt |
| link_en | output | 1 | Link enable to the serializer |
| bclk_dir | output | 1 | Bit-clock direction select |
| fmt_bits | output | 6 | Framing options to the serializer |
| clk_div | output | DIV_W | Bit-clock divider value |

## Verification
Read data and tx_word are combinational from the current state, so they are due in the very cycle the strobe is held, before the edge that pops; register writes, queue levels, sticky flags, requests and irq all change on the edge that takes the strobe and are due one cycle later. The bench drives every strobe at a falling edge for exactly one cycle and samples a short delay after that falling edge, so each value is read either in the strobe cycle (read data, playback word) or after the strobe has been released (everything else). The playback and capture scoreboards hold the words the bench expects, skipping those that a full queue must drop.

// File: rtl/aud_pkg.sv
// Shared offsets and field positions for the serial-audio register unit.
// Assumes byte addressing with word-aligned registers.
package aud_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_MAIN = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_FRAM = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_IEN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_ACK  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_DIV  = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_DATA = 8'h80;

    // main control bit positions
    localparam int MC_LINK  = 0;
    localparam int MC_BCLK  = 2;
    localparam int MC_SRST  = 3;
    localparam logic [15:0] MC_KEEP = 16'hFF3F;

    // status / enable / acknowledge bit positions
    localparam int ST_OFF  = 7;
    localparam int ST_OVR  = 6;
    localparam int ST_UDR  = 5;
    localparam int ST_RREQ = 4;
    localparam int ST_TREQ = 3;

    typedef struct packed {
        logic ovr;
        logic udr;
        logic rreq;
        logic treq;
    } evt_t;
endpackage

// File: rtl/aud_sfifo.sv
// Synchronous word queue with show-ahead head output.
// Assumes DEPTH is a power of two; push when full and pop when empty are
// ignored; head reads 0 while empty; clr empties the queue.
module aud_sfifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rp];

    // store an accepted word
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/aud_evt_ctl.sv
// Service requests, sticky error flags and the combined interrupt.
// Assumes set wins over an acknowledge in the same cycle; clr (soft reset)
// wins over both.
module aud_evt_ctl #(
    parameter int LW = 5,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ovr_set,
    input  logic          udr_set,
    input  logic          ovr_ack,
    input  logic          udr_ack,
    input  logic [LW-1:0] tx_lvl,
    input  logic [LW-1:0] rx_lvl,
    input  logic [TW-1:0] tx_th,
    input  logic [TW-1:0] rx_th,
    input  aud_pkg::evt_t ien,
    output aud_pkg::evt_t evt,
    output logic          irq
);
    logic ovr_q, udr_q;

    // sticky overrun / underrun flags
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovr_q <= 1'b0;
            udr_q <= 1'b0;
        end else begin
            ovr_q <= ovr_set || (ovr_q && !ovr_ack);
            udr_q <= udr_set || (udr_q && !udr_ack);
        end
    end

    // level comparisons and event vector
    always_comb begin
        evt.ovr  = ovr_q;
        evt.udr  = udr_q;
        evt.treq = (tx_lvl <= LW'(tx_th));
        evt.rreq = (rx_lvl >= LW'(rx_th));
    end

    assign irq = |(evt & ien);
endmodule

// File: rtl/aud_fifo_regs.sv
// Register front end of a stereo serial-audio port: control, status,
// interrupt enable/acknowledge, divider and a shared data window that pushes
// the playback queue on write and pops the capture queue on read.
// Assumes single-cycle strobes and combinational read data.
module aud_fifo_regs #(
    parameter int DEPTH = 16,
    parameter int DIV_W = 7,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int AW8  = aud_pkg::ADDR_W,
    localparam int DW   = aud_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [AW8-1:0]   reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             tx_pop,
    output logic [DW-1:0]    tx_word,
    input  logic             rx_push,
    input  logic [DW-1:0]    rx_word,
    output logic             tx_dreq,
    output logic             rx_dreq,
    output logic             irq,
    output logic             link_en,
    output logic             bclk_dir,
    output logic [5:0]       fmt_bits,
    output logic [DIV_W-1:0] clk_div
);
    import aud_pkg::*;

    logic [15:0]      main_q;
    logic [5:0]       fram_q;
    evt_t             ien_q;
    logic [DIV_W-1:0] div_q;
    logic             soft_rst;
    logic [LW-1:0]    tx_lvl, rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0]    rx_head;
    evt_t             evt;
    logic             wr_main, wr_fram, wr_ien, wr_ack, wr_div, wr_data, rd_data;

    assign soft_rst = main_q[MC_SRST];
    assign wr_main  = reg_wr && (reg_addr == OFF_MAIN);
    assign wr_fram  = reg_wr && (reg_addr == OFF_FRAM);
    assign wr_ien   = reg_wr && (reg_addr == OFF_IEN);
    assign wr_ack   = reg_wr && (reg_addr == OFF_ACK);
    assign wr_div   = reg_wr && (reg_addr == OFF_DIV);
    assign wr_data  = reg_wr && (reg_addr == OFF_DATA);
    assign rd_data  = reg_rd && (reg_addr == OFF_DATA);

    // main control: only cleared by the pin reset, so software can release soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)       main_q <= '0;
        else if (wr_main) main_q <= reg_wdata[15:0] & MC_KEEP;
    end

    // remaining writable registers, held at reset value during soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            fram_q <= '0;
            ien_q  <= '0;
            div_q  <= '0;
        end else begin
            if (wr_fram) fram_q <= reg_wdata[5:0];
            if (wr_ien)  ien_q  <= reg_wdata[ST_OVR:ST_TREQ];
            if (wr_div)  div_q  <= reg_wdata[DIV_W-1:0];
        end
    end

    aud_sfifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(wr_data && !soft_rst), .pop(tx_pop), .din(reg_wdata),
        .head(tx_word), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    aud_sfifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(rx_push), .pop(rd_data && !soft_rst), .din(rx_word),
        .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    aud_evt_ctl #(.LW(LW), .TW(4)) u_evt (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .ovr_set(rx_push && rx_full), .udr_set(tx_pop && tx_empty),
        .ovr_ack(wr_ack && reg_wdata[ST_OVR]), .udr_ack(wr_ack && reg_wdata[ST_UDR]),
        .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .tx_th(main_q[11:8]), .rx_th(main_q[15:12]),
        .ien(ien_q), .evt(evt), .irq(irq)
    );

    assign tx_dreq  = evt.treq;
    assign rx_dreq  = evt.rreq;
    assign link_en  = main_q[MC_LINK];
    assign bclk_dir = main_q[MC_BCLK];
    assign fmt_bits = fram_q;
    assign clk_div  = div_q;

    // read-data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_MAIN: reg_rdata = DW'(main_q);
            OFF_FRAM: reg_rdata = DW'(fram_q);
            OFF_STAT: reg_rdata = DW'({!link_en, evt.ovr, evt.udr, evt.rreq, evt.treq,
                                       link_en && !tx_empty, !rx_empty, !tx_full});
            OFF_IEN:  reg_rdata = DW'({ien_q, 3'b000});
            OFF_DIV:  reg_rdata = DW'(div_q);
            OFF_DATA: reg_rdata = rx_head;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/aud_fifo_regs_chk.sv
// Property checker for aud_fifo_regs, attached by bind below.
// Assumes the synchronous active-low reset of the checked block.
module aud_fifo_regs_chk #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [7:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          tx_pop,
    input logic [31:0]   tx_word,
    input logic          rx_push,
    input logic          irq,
    input logic [LW-1:0] tx_lvl,
    input logic [LW-1:0] rx_lvl,
    input logic          soft_rst,
    input logic [3:0]    ien,
    input logic          ovr,
    input logic          udr
);
    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

    a_r6_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_lvl == '0) |-> (tx_word == '0));

    a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_lvl == '0 && !soft_rst) |=> udr);

    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_lvl == LW'(DEPTH) && !soft_rst) |=> ovr);

    a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_lvl == LW'(DEPTH) && !soft_rst && !(reg_rd && reg_addr == 8'h80))
        |=> (rx_lvl == LW'(DEPTH)));

    a_r7_ack_clears_udr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h18 && reg_wdata[5] && !(tx_pop && tx_lvl == '0)) |=> !udr);

    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 4'b0) |-> !irq);

    a_r11_soft_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_lvl == '0 && rx_lvl == '0 && !ovr && !udr));
endmodule

bind aud_fifo_regs aud_fifo_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tx_pop(tx_pop),
    .tx_word(tx_word), .rx_push(rx_push), .irq(irq),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .soft_rst(soft_rst),
    .ien(ien_q), .ovr(evt.ovr), .udr(evt.udr)
);

// File: tb/sim_aud_fifo_regs.sv
// Scoreboard bench for aud_fifo_regs: driver tasks queue expected words,
// a monitor compares playback words as the serializer pops them.
module sim_aud_fifo_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        tx_pop = 1'b0, rx_push = 1'b0;
    logic [31:0] tx_word, rx_word = '0;
    logic        tx_dreq, rx_dreq, irq, link_en, bclk_dir;
    logic [5:0]  fmt_bits;
    logic [6:0]  clk_div;

    int checks = 0, fails = 0;
    logic [31:0] tx_q[$];
    logic [31:0] rx_q[$];

    always #2 clk = ~clk;

    aud_fifo_regs u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_word(tx_word), .rx_push(rx_push), .rx_word(rx_word),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq), .irq(irq), .link_en(link_en),
        .bclk_dir(bclk_dir), .fmt_bits(fmt_bits), .clk_div(clk_div)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        #1;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
        #1;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        bus_rd(a, v);
        chk(v, exp, tag);
    endtask

    // driver: playback word, expected only if the queue has room
    task automatic drv_tx(input logic [31:0] w);
        bus_wr(8'h80, w);
        if (tx_q.size() < 16) tx_q.push_back(w);
    endtask

    task automatic ser_pop();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
        #1;
    endtask

    // driver: captured word, expected only if the queue has room
    task automatic ser_push(input logic [31:0] w);
        @(negedge clk); rx_push = 1'b1; rx_word = w;
        @(negedge clk); rx_push = 1'b0;
        if (rx_q.size() < 16) rx_q.push_back(w);
        #1;
    endtask

    task automatic rd_rx(input string tag);
        logic [31:0] v, exp;
        bus_rd(8'h80, v);
        exp = (rx_q.size() != 0) ? rx_q.pop_front() : 32'h0;
        chk(v, exp, tag);
    endtask

    // monitor: compare each popped playback word with the scoreboard
    always @(negedge clk) begin
        #1;
        if (tx_pop) begin
            if (tx_q.size() != 0) chk(tx_word, tx_q.pop_front(), "R3 playback order");
            else                  chk(tx_word, 32'h0, "R6 underrun word");
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd_chk(8'h0C, 32'h99, "R1 status");
        rd_chk(8'h00, 32'h0, "R1 main");
        rd_chk(8'h04, 32'h0, "R1 framing");
        rd_chk(8'h14, 32'h0, "R1 enable");
        rd_chk(8'h60, 32'h0, "R1 divider");

        // R2 readback with masking
        bus_wr(8'h00, 32'hFFFF_3105);
        rd_chk(8'h00, 32'h3105, "R2 main");
        bus_wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h3F, "R2 framing");
        chk(32'(fmt_bits), 32'h3F, "R2 fmt_bits");
        bus_wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'h78, "R2 enable");
        bus_wr(8'h60, 32'hFFFF_FFFF);
        rd_chk(8'h60, 32'h7F, "R2 divider");
        chk(32'(clk_div), 32'h7F, "R2 clk_div");
        bus_wr(8'h14, 32'h0);
        chk(32'(link_en), 32'h1, "R12 link_en");
        chk(32'(bclk_dir), 32'h1, "R12 bclk_dir");
        rd_chk(8'h0C, 32'h09, "R12 status idle on");

        // R8 playback threshold (1)
        chk(32'(tx_dreq), 32'h1, "R8 request at level 0");
        drv_tx(32'hA000_0001);
        chk(32'(tx_dreq), 32'h1, "R8 request at level 1");
        drv_tx(32'hA000_0002);
        chk(32'(tx_dreq), 32'h0, "R8 no request at level 2");
        rd_chk(8'h0C, 32'h05, "R12 busy");

        // R3 fill, overfill, drain
        for (int i = 3; i <= 16; i++) drv_tx(32'hA000_0000 + 32'(i));
        rd_chk(8'h0C, 32'h04, "R3 full status");
        drv_tx(32'hDEAD_BEEF);
        for (int i = 0; i < 16; i++) ser_pop();
        rd_chk(8'h0C, 32'h09, "R3 drained status");

        // R6 underrun, R10 irq, R7 acknowledge
        ser_pop();
        rd_chk(8'h0C, 32'h29, "R6 sticky underrun");
        chk(32'(irq), 32'h0, "R10 irq disabled");
        bus_wr(8'h14, 32'h20);
        chk(32'(irq), 32'h1, "R10 irq underrun enabled");
        bus_wr(8'h18, 32'h40);
        rd_chk(8'h0C, 32'h29, "R7 other bit leaves flag");
        bus_wr(8'h18, 32'h20);
        rd_chk(8'h0C, 32'h09, "R7 acknowledge clears");
        chk(32'(irq), 32'h0, "R7 irq drops");
        bus_wr(8'h14, 32'h08);
        chk(32'(irq), 32'h1, "R10 irq playback request");
        bus_wr(8'h14, 32'h0);

        // R9 capture threshold (3), R4 order and empty read
        ser_push(32'hB000_0001);
        ser_push(32'hB000_0002);
        chk(32'(rx_dreq), 32'h0, "R9 no request at level 2");
        ser_push(32'hB000_0003);
        chk(32'(rx_dreq), 32'h1, "R9 request at level 3");
        rd_chk(8'h0C, 32'h1B, "R9 status");
        for (int i = 0; i < 3; i++) rd_rx("R4 capture order");
        rd_rx("R4 empty read zero");
        rd_chk(8'h0C, 32'h09, "R4 empty read no effect");

        // R5 overrun and 16-read drain
        for (int i = 1; i <= 17; i++) ser_push(32'hC000_0000 + 32'(i));
        rd_chk(8'h0C, 32'h5B, "R5 sticky overrun");
        bus_wr(8'h14, 32'h40);
        chk(32'(irq), 32'h1, "R10 irq overrun enabled");
        for (int i = 0; i < 16; i++) rd_rx("R5 capture kept words");
        rd_chk(8'h0C, 32'h49, "R4 drained after sixteen reads");
        rd_rx("R4 empty after drain");
        bus_wr(8'h18, 32'h40);
        rd_chk(8'h0C, 32'h09, "R7 overrun acknowledged");

        // R11 soft reset
        drv_tx(32'hE000_0001);
        ser_push(32'hE000_0002);
        bus_wr(8'h14, 32'h78);
        bus_wr(8'h60, 32'h5);
        bus_wr(8'h00, 32'h310D);
        tx_q.delete();
        rx_q.delete();
        rd_chk(8'h00, 32'h310D, "R11 main kept");
        rd_chk(8'h14, 32'h0, "R11 enable cleared");
        rd_chk(8'h60, 32'h0, "R11 divider cleared");
        rd_chk(8'h0C, 32'h09, "R11 queues empty");
        bus_wr(8'h60, 32'h22);
        rd_chk(8'h60, 32'h0, "R11 write ignored");
        bus_wr(8'h00, 32'h3105);
        rd_chk(8'h60, 32'h0, "R11 divider after release");
        rd_rx("R11 capture empty after release");

        // R12 link off
        bus_wr(8'h00, 32'h0);
        rd_chk(8'h0C, 32'h99, "R12 off status");
        chk(32'(link_en), 32'h0, "R12 link off");
        bus_wr(8'h00, 32'h1);
        chk(32'(bclk_dir), 32'h0, "R12 bclk_dir low");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule